// File: doc/BRIEF.md
# I2C Byte-Complete Interrupt and Clock-Hold Control

This block owns the pending flag of an I2C controller. The flag rests at 1 while the bus engine may run. When the falling edge of the final SCL clock of a byte arrives (the acknowledge clock counts as part of the byte) and a qualifying completion is reported, the flag drops to 0. For as long as the flag stays 0, the block asks the SCL driver to hold the line low and to stop generating clocks. In the cycle where the flag first reads 0, the block raises a one-cycle interrupt request.

A qualifying completion is one of the following:
- a transmitted byte, including a byte during which arbitration was lost;
- a received byte;
- in slave receive mode, an address event. Which address events count depends on a reporting-mode input.

Firmware lets the transfer continue by writing the data shift register. The flag also returns to 1 in three other cases: software writes 1 to it, the interface is disabled, or reset is applied. Bit shifting and the pin drivers are not part of this block.

Top module: `i2c_byte_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block sets `pend_flag` to 1 and drives `irq_pulse` and `scl_hold` to 0.
- R2: When `last_clk_fall` is 1 together with `tx_done` or `rx_done`, and no set cause is active, `pend_flag` reads 0 after the next rising edge.
- R3: When `last_clk_fall` is 1 together with `arb_lost` and no set cause is active, `pend_flag` is cleared. This holds even if `tx_done` is 0.
- R4: With `slave_rx`=1 and `addr_rpt_all`=0, `last_clk_fall` together with `own_match` or `gcall_match` clears the flag. In this mode `addr_byte` alone does not clear it.
- R5: With `slave_rx`=1 and `addr_rpt_all`=1, `last_clk_fall` together with `addr_byte` clears the flag. In this mode `own_match` and `gcall_match` alone do not clear it. When `slave_rx`=0, all three address inputs are ignored.
- R6: No clear happens unless `last_clk_fall` and a qualifying completion are both present. A qualifier without `last_clk_fall` leaves the flag unchanged, and so does `last_clk_fall` without a qualifier.
- R7: The flag is set to 1 by any of these causes: `dat_wr`=1, `enable`=0, or `sw_wr`=1 with `sw_wdata`=1. A software write with `sw_wdata`=0 has no effect on the flag.
- R8: If a set cause and a clear cause occur in the same cycle, the flag ends at 1.
- R9: `irq_pulse` is 1 for exactly one cycle, namely the first cycle in which `pend_flag` reads 0 after reading 1. Holding the flag at 0 produces no further pulses.
- R10: `scl_hold` equals the inverse of `pend_flag` at all times. Once raised, it drops only after one of the set causes listed in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Interface enable; 0 forces the flag to 1 |
| addr_rpt_all | input | 1 | Address reporting mode: 0 = only matches clear the flag, 1 = any address byte clears it |
| slave_rx | input | 1 | Controller is in slave receive mode |
| last_clk_fall | input | 1 | Strobe for the falling edge of the final SCL clock of a byte, acknowledge clock included |
| tx_done | input | 1 | A byte has been transmitted |
| rx_done | input | 1 | A byte has been received |
| arb_lost | input | 1 | Arbitration was lost during the current byte |
| own_match | input | 1 | The received address matches the own address |
| gcall_match | input | 1 | The received address is the general-call address |
| addr_byte | input | 1 | An address byte has been received |
| dat_wr | input | 1 | Write strobe for the data shift register |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Value carried by the software write |
| pend_flag | output | 1 | Pending flag; 0 means a byte is complete and the clock is held |
| irq_pulse | output | 1 | One-cycle interrupt request, raised when the flag falls |
| scl_hold | output | 1 | Request to hold SCL low and stop clock generation |

## Verification
The hardest cases to reach are the address-mode qualifiers. An address event changes the flag only when it lines up with `last_clk_fall`, `slave_rx` is 1, the flag is already 1, and no set cause is active in the same cycle. Random stimulus seldom produces that combination. The directed cases therefore first bring the flag back to 1 with a data write, and only then apply each address input under both reporting modes. Random cycles keep set causes rare so that the flag spends long stretches at 0; this exercises the absence of repeated pulses and the set-over-clear priority.

// File: rtl/i2c_bic_pkg.sv
// Package: shared types for the byte-complete interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_bic_pkg;
    typedef enum logic {
        RPT_MATCH_ONLY = 1'b0,
        RPT_ANY_ADDR   = 1'b1
    } addr_rpt_e;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic arb_lost;
        logic own_match;
        logic gcall_match;
        logic addr_byte;
    } byte_evt_t;

    localparam logic FLAG_IDLE = 1'b1;
endpackage

// File: rtl/i2c_bic_cause.sv
// Module: decodes the set and clear causes of the pending flag.
// Assumes: event inputs are single-cycle strobes or stable levels, all
// synchronous to clk. A clear needs the last-clock-fall strobe.
module i2c_bic_cause
    import i2c_bic_pkg::*;
(
    input  logic      enable,
    input  addr_rpt_e rpt_mode,
    input  logic      slave_rx,
    input  logic      last_clk_fall,
    input  byte_evt_t evt,
    input  logic      dat_wr,
    input  logic      sw_wr,
    input  logic      sw_wdata,
    output logic      set_evt,
    output logic      clr_evt
);
    logic addr_q;

    // Select which address event qualifies, depending on the reporting mode.
    always_comb begin
        if (!slave_rx)
            addr_q = 1'b0;
        else if (rpt_mode == RPT_ANY_ADDR)
            addr_q = evt.addr_byte;
        else
            addr_q = evt.own_match | evt.gcall_match;
    end

    // Combine byte completions with the last-clock-fall strobe.
    always_comb begin
        clr_evt = last_clk_fall & (evt.tx_done | evt.rx_done | evt.arb_lost | addr_q);
    end

    // Collect every cause that returns the flag to its idle value.
    always_comb begin
        set_evt = dat_wr | ~enable | (sw_wr & sw_wdata);
    end
endmodule

// File: rtl/i2c_bic_flag.sv
// Module: holds the pending flag. A set cause takes priority over a clear cause.
// Assumes: synchronous active-low reset; reset leaves the flag at its idle value 1.
module i2c_bic_flag
    import i2c_bic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag_q,
    output logic flag_d
);
    // Work out the next flag value, with set winning over clear.
    always_comb begin
        if (set_evt)      flag_d = 1'b1;
        else if (clr_evt) flag_d = 1'b0;
        else              flag_d = flag_q;
    end

    // Register the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= FLAG_IDLE;
        else        flag_q <= flag_d;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);
    assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_evt));
    assert_rise_needs_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_evt));
endmodule

// File: rtl/i2c_bic_irq.sv
// Module: produces a one-cycle interrupt request on each 1-to-0 edge of the flag.
// Assumes: flag_d is the value the flag takes at the next edge, so the pulse
// lines up with the first cycle in which the flag reads 0.
module i2c_bic_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_q,
    input  logic flag_d,
    output logic irq_q
);
    // Register the falling edge of the flag as a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= flag_q & ~flag_d;
    end

    assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!flag_q && $past(flag_q)));
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
endmodule

// File: rtl/i2c_byte_irq_ctrl.sv
// Module: top level of the byte-complete interrupt and SCL hold control.
// Assumes: all inputs are synchronous to clk, and the SCL driver acts on scl_hold.
module i2c_byte_irq_ctrl
    import i2c_bic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic addr_rpt_all,
    input  logic slave_rx,
    input  logic last_clk_fall,
    input  logic tx_done,
    input  logic rx_done,
    input  logic arb_lost,
    input  logic own_match,
    input  logic gcall_match,
    input  logic addr_byte,
    input  logic dat_wr,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic pend_flag,
    output logic irq_pulse,
    output logic scl_hold
);
    byte_evt_t evt;
    addr_rpt_e rpt_mode;
    logic      set_evt, clr_evt, flag_q, flag_d;

    // Gather the byte events into one bundle and pick the reporting mode.
    always_comb begin
        evt      = '{tx_done: tx_done, rx_done: rx_done, arb_lost: arb_lost,
                     own_match: own_match, gcall_match: gcall_match,
                     addr_byte: addr_byte};
        rpt_mode = addr_rpt_all ? RPT_ANY_ADDR : RPT_MATCH_ONLY;
    end

    i2c_bic_cause u_cause (
        .enable(enable), .rpt_mode(rpt_mode), .slave_rx(slave_rx),
        .last_clk_fall(last_clk_fall), .evt(evt), .dat_wr(dat_wr),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .set_evt(set_evt), .clr_evt(clr_evt)
    );

    i2c_bic_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
        .flag_q(flag_q), .flag_d(flag_d)
    );

    i2c_bic_irq u_irq (
        .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .flag_d(flag_d),
        .irq_q(irq_pulse)
    );

    // Drive the outputs: the hold request follows the inverse of the flag.
    always_comb begin
        pend_flag = flag_q;
        scl_hold  = ~flag_q;
    end

    assert_any_addr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && addr_rpt_all && slave_rx && last_clk_fall && addr_byte &&
         !dat_wr && !(sw_wr && sw_wdata)) |=> !pend_flag);
    assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold) |-> $past(dat_wr || !enable || (sw_wr && sw_wdata)));
    assert_tx_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && last_clk_fall && tx_done && !dat_wr && !(sw_wr && sw_wdata))
        |=> (!pend_flag && scl_hold));
endmodule

// File: tb/tb_i2c_byte_irq_ctrl.sv
module tb_i2c_byte_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic enable, addr_rpt_all, slave_rx, last_clk_fall;
    logic tx_done, rx_done, arb_lost, own_match, gcall_match, addr_byte;
    logic dat_wr, sw_wr, sw_wdata;
    logic pend_flag, irq_pulse, scl_hold;

    int checks = 0;
    int errors = 0;
    logic exp_flag = 1'b1;
    logic exp_irq  = 1'b0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    i2c_byte_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .addr_rpt_all(addr_rpt_all),
        .slave_rx(slave_rx), .last_clk_fall(last_clk_fall), .tx_done(tx_done),
        .rx_done(rx_done), .arb_lost(arb_lost), .own_match(own_match),
        .gcall_match(gcall_match), .addr_byte(addr_byte), .dat_wr(dat_wr),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .pend_flag(pend_flag),
        .irq_pulse(irq_pulse), .scl_hold(scl_hold)
    );

    // Next flag value, computed directly from the requirements.
    function automatic logic model_next(logic cur);
        logic set_c, addr_c, clr_c;
        set_c  = dat_wr || !enable || (sw_wr && sw_wdata);
        addr_c = slave_rx && (addr_rpt_all ? addr_byte : (own_match || gcall_match));
        clr_c  = last_clk_fall && (tx_done || rx_done || arb_lost || addr_c);
        if (!rst_n) return 1'b1;
        if (set_c)  return 1'b1;
        if (clr_c)  return 1'b0;
        return cur;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        enable = 1; addr_rpt_all = 0; slave_rx = 0; last_clk_fall = 0;
        tx_done = 0; rx_done = 0; arb_lost = 0; own_match = 0; gcall_match = 0;
        addr_byte = 0; dat_wr = 0; sw_wr = 0; sw_wdata = 0;
    endtask

    // Apply the current inputs for one edge, update the model, and compare at the falling edge.
    task automatic step(input string req);
        logic nxt;
        @(posedge clk);
        nxt      = model_next(exp_flag);
        exp_irq  = rst_n && exp_flag && !nxt;
        exp_flag = nxt;
        @(negedge clk);
        chk(req, pend_flag, exp_flag, "pend_flag");
        chk(req, irq_pulse, exp_irq, "irq_pulse");
        chk("R10", scl_hold, ~exp_flag, "scl_hold");
        idle_inputs();
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        // R2: transmit and receive completions
        last_clk_fall = 1; tx_done = 1; step("R2");
        step("R9");                                   // held low: no second pulse
        dat_wr = 1; step("R10");
        last_clk_fall = 1; rx_done = 1; step("R2");
        sw_wr = 1; sw_wdata = 1; step("R7");
        // R3: arbitration lost alone
        last_clk_fall = 1; arb_lost = 1; step("R3");
        sw_wr = 1; sw_wdata = 0; step("R7");          // writing 0 has no effect
        enable = 0; step("R7");
        // R6: qualifier without strobe, strobe without qualifier
        tx_done = 1; rx_done = 1; step("R6");
        last_clk_fall = 1; step("R6");
        // R4: match-only reporting mode
        slave_rx = 1; last_clk_fall = 1; addr_byte = 1; step("R4");
        slave_rx = 1; last_clk_fall = 1; own_match = 1; step("R4");
        dat_wr = 1; step("R7");
        slave_rx = 1; last_clk_fall = 1; gcall_match = 1; step("R4");
        dat_wr = 1; step("R7");
        // R5: any-address reporting mode
        addr_rpt_all = 1; slave_rx = 1; last_clk_fall = 1; own_match = 1; gcall_match = 1; step("R5");
        addr_rpt_all = 1; slave_rx = 0; last_clk_fall = 1; addr_byte = 1; step("R5");
        addr_rpt_all = 1; slave_rx = 1; last_clk_fall = 1; addr_byte = 1; step("R5");
        dat_wr = 1; step("R7");
        // R8: set and clear in the same cycle
        last_clk_fall = 1; tx_done = 1; dat_wr = 1; step("R8");
        last_clk_fall = 1; rx_done = 1; sw_wr = 1; sw_wdata = 1; step("R8");
        // Random stimulus, with set causes kept rare.
        for (int i = 0; i < 3000; i++) begin
            enable        = ($urandom % 40) != 0;
            addr_rpt_all  = $urandom % 2;
            slave_rx      = $urandom % 2;
            last_clk_fall = ($urandom % 3) == 0;
            tx_done       = ($urandom % 5) == 0;
            rx_done       = ($urandom % 5) == 0;
            arb_lost      = ($urandom % 8) == 0;
            own_match     = ($urandom % 4) == 0;
            gcall_match   = ($urandom % 6) == 0;
            addr_byte     = ($urandom % 4) == 0;
            dat_wr        = ($urandom % 12) == 0;
            sw_wr         = ($urandom % 10) == 0;
            sw_wdata      = $urandom % 2;
            step("R8 R9 random");
        end
        rst_n = 0; last_clk_fall = 1; tx_done = 1; step("R1");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule